// File: doc/BRIEF.md
# Pin Controller with Interrupt Cause Capture

This block controls a bank of general-purpose pins through a small word-addressed register bus. For each pin, software chooses whether the pin is an input or an output, the value it drives, whether it blinks, and how its input level is interpreted. The pin levels come in through a two-stage synchroniser. They are then XORed with the per-pin polarity bit. The adjusted value feeds both the readable input register and the interrupt logic. Because of this, a single rising-edge detector and a single active-high level path cover rising, falling, high and low triggers.

Edge events are latched in a cause register. Software clears a cause bit by writing a zero to it. Latched edges gated by an edge mask are combined with current levels gated by a level mask, and the result drives one interrupt line. A blink generator is built from a shared prescaler and a phase flop. It can replace the driven value of any output pin with a square wave.

The bus carries a 3-bit word index. Index k selects the register at byte offset 4*k.

Top module: `pin_ctrl_unit`

## Requirements
- R1: After reset, the direction register reads all ones (every pin an input), and the output, blink, polarity, edge-cause, edge-mask and level-mask registers read zero. `pin_oe` and `irq` are 0.
- R2: Word index 0 is the output value, 1 the direction, 2 the blink enable, 3 the polarity, 4 the input data, 5 the edge cause, 6 the edge mask and 7 the level mask. Indexes 0-3, 6 and 7 read back what was last written. A write takes effect at the clock edge where `bus_wr` is sampled high, and reads are combinational.
- R3: `pin_oe` bit n is 1 exactly when direction bit n is 0. When blink bit n is 0, `pin_out` bit n equals output-value bit n.
- R4: The input data register reads the synchronised pin level XOR the polarity bit. A pin change driven before a clock edge is visible after the second clock edge, and not after the first.
- R5: An edge-cause bit sets one clock edge after its adjusted input rises. With polarity 0 this is a rising pin edge; with polarity 1 it is a falling pin edge. An edge in the opposite direction sets nothing.
- R6: A write to the edge-cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: If an edge sets a cause bit at the same clock edge that a write clears it, the bit ends at 1.
- R8: `irq` is the OR over all pins of (input data AND level mask) OR (edge cause AND edge mask).
- R9: When blink bit n is 1, `pin_out` bit n follows a shared phase that toggles once every BLINK_TC clock cycles, whatever the output value. Clearing the blink bit returns the pin to its output-value bit.
- R10: Writes to the input data register have no effect on its readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_idx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_idx` |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Driven pin values |
| pin_oe | output | NPINS | Pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted synchroniser or previous-value flop shows up within two or three cycles as a wrong input readback or as a spurious or missing cause bit. The bench therefore samples the cycle before and the cycle after the expected arrival. A bad clear-versus-set ordering is visible as a cause bit lost on the exact edge where a clear and a rising edge coincide. Prescaler miscounts show directly as a wrong spacing between `pin_out` toggles. Mask or combine mistakes show in the same cycle as a wrong level on `irq`.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    localparam logic [IDX_W-1:0] IDX_OUT   = 3'd0;
    localparam logic [IDX_W-1:0] IDX_DIR   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_BLINK = 3'd2;
    localparam logic [IDX_W-1:0] IDX_POL   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_DIN   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_CAUSE = 3'd5;
    localparam logic [IDX_W-1:0] IDX_EMASK = 3'd6;
    localparam logic [IDX_W-1:0] IDX_LMASK = 3'd7;
endpackage

// File: rtl/pin_sense.sv
module pin_sense #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] din,
    output logic [NPINS-1:0] rise
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] prev;
    } sense_t;

    sense_t st_d, st_q;
    logic [NPINS-1:0] adj;

    always_comb begin
        adj       = st_q.s2 ^ pol;
        st_d      = st_q;
        st_d.s1   = pin_in;
        st_d.s2   = st_q.s1;
        st_d.prev = adj;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign din  = adj;
    assign rise = adj & ~st_q.prev;

    // R5: a detected edge lasts a single cycle per bit
    p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/blink_tick.sv
module blink_tick #(
    parameter int BLINK_TC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (BLINK_TC > 1) ? $clog2(BLINK_TC) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLINK_TC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } tick_t;

    tick_t st_d, st_q;
    logic  tick;

    always_comb begin
        tick = (st_q.cnt == LAST);
        st_d = st_q;
        if (tick) begin
            st_d.cnt = '0;
            st_d.ph  = ~st_q.ph;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;

    // R9: terminal count pulses never come back to back when the period exceeds one
    p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (BLINK_TC > 1 && tick) |=> !tick);
endmodule

// File: rtl/pin_ctrl_unit.sv
module pin_ctrl_unit
    import pin_ctrl_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int BLINK_TC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] out;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] blink;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] cause;
        logic [NPINS-1:0] emask;
        logic [NPINS-1:0] lmask;
    } regs_t;

    regs_t r_d, r_q;
    logic [NPINS-1:0] wdat, din, rise, cause_q;
    logic             phase, cause_wr;

    assign wdat = bus_wdata[NPINS-1:0];

    pin_sense #(.NPINS(NPINS)) u_sense (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol(r_q.pol),
        .din(din), .rise(rise)
    );

    blink_tick #(.BLINK_TC(BLINK_TC)) u_blink (
        .clk(clk), .rst_n(rst_n), .phase(phase)
    );

    always_comb begin
        r_d      = r_q;
        cause_wr = bus_wr && (bus_idx == IDX_CAUSE);
        if (bus_wr) begin
            case (bus_idx)
                IDX_OUT:   r_d.out   = wdat;
                IDX_DIR:   r_d.dir   = wdat;
                IDX_BLINK: r_d.blink = wdat;
                IDX_POL:   r_d.pol   = wdat;
                IDX_CAUSE: r_d.cause = r_q.cause & wdat;
                IDX_EMASK: r_d.emask = wdat;
                IDX_LMASK: r_d.lmask = wdat;
                default:   ;
            endcase
        end
        r_d.cause = r_d.cause | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dir <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_idx)
            IDX_OUT:   bus_rdata = DATA_W'(r_q.out);
            IDX_DIR:   bus_rdata = DATA_W'(r_q.dir);
            IDX_BLINK: bus_rdata = DATA_W'(r_q.blink);
            IDX_POL:   bus_rdata = DATA_W'(r_q.pol);
            IDX_DIN:   bus_rdata = DATA_W'(din);
            IDX_CAUSE: bus_rdata = DATA_W'(r_q.cause);
            IDX_EMASK: bus_rdata = DATA_W'(r_q.emask);
            default:   bus_rdata = DATA_W'(r_q.lmask);
        endcase
    end

    assign cause_q = r_q.cause;
    assign pin_oe  = ~r_q.dir;
    assign pin_out = (r_q.out & ~r_q.blink) | ({NPINS{phase}} & r_q.blink);
    assign irq     = |((din & r_q.lmask) | (r_q.cause & r_q.emask));

    // R6: a clearing write with no coincident edge leaves only the bits written as 1
    p_cause_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr && rise == '0) |=> (cause_q == ($past(cause_q) & $past(wdat))));

    // R7: every detected edge is held in the cause register on the next cycle
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((cause_q & $past(rise)) == $past(rise)));

    // R8: with both masks clear the interrupt stays low
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.emask == '0 && r_q.lmask == '0) |-> !irq);

    // R5: cause bits only rise where an edge was detected
    p_cause_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & ~$past(cause_q)) & ~$past(rise)) == '0);
endmodule

// File: tb/tb_pin_ctrl_unit.sv
module tb_pin_ctrl_unit;
    localparam int NP = 32;
    localparam int TC = 5;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          bus_wr = 0;
    logic [2:0]    bus_idx = 0;
    logic [31:0]   bus_wdata = 0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = 0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;
    logic [31:0]   probe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t q[$];
    event  ev;

    always #10 clk = ~clk;

    pin_ctrl_unit #(.NPINS(NP), .BLINK_TC(TC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // monitor: pops expected items and compares with the design outputs
    initial begin
        forever begin
            @(ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = bus_rdata;
                    1: act = pin_out;
                    2: act = pin_oe;
                    3: act = {31'd0, irq};
                    default: act = probe;
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input int sel, input logic [31:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
        -> ev;
        #1;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string req);
        bus_idx = idx;
        #1;
        chk(0, exp, req);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(2);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        rd(0, 32'h0, "R1 out");
        rd(1, 32'hFFFF_FFFF, "R1 dir");
        rd(2, 32'h0, "R1 blink");
        rd(3, 32'h0, "R1 pol");
        rd(5, 32'h0, "R1 cause");
        rd(6, 32'h0, "R1 emask");
        rd(7, 32'h0, "R1 lmask");
        chk(2, 32'h0, "R1 pin_oe");
        chk(3, 32'h0, "R1 irq");

        // R2 readback
        wr(0, 32'hA5A5_0F0F); rd(0, 32'hA5A5_0F0F, "R2 out");
        wr(6, 32'h1234_5678); rd(6, 32'h1234_5678, "R2 emask");
        wr(7, 32'h8765_4321); rd(7, 32'h8765_4321, "R2 lmask");
        wr(6, 0); wr(7, 0);

        // R3 direction and output drive
        wr(1, 32'hFFFF_0000);
        chk(2, 32'h0000_FFFF, "R3 pin_oe");
        chk(1, 32'hA5A5_0F0F, "R3 pin_out");

        // R10 input register ignores writes
        wr(4, 32'hFFFF_FFFF);
        rd(4, 32'h0, "R10 din");

        // R4 two-edge latency
        bus_idx = 4;
        @(negedge clk); pin_in = 32'h0000_00F0;
        @(negedge clk); rd(4, 32'h0, "R4 after one edge");
        @(negedge clk); rd(4, 32'h0000_00F0, "R4 after two edges");
        @(negedge clk); rd(5, 32'h0000_00F0, "R5 rising edge cause");

        // R6 write-zero clear
        wr(5, 32'hFFFF_FF3F); rd(5, 32'h0000_0030, "R6 partial clear");
        wr(5, 32'h0); rd(5, 32'h0, "R6 full clear");

        // R4 polarity; R5 falling edge via polarity 1
        wr(3, 32'h0000_0100);
        rd(4, 32'h0000_01F0, "R4 polarity xor");
        cyc(2);
        wr(5, 32'h0);
        rd(5, 32'h0, "R5 clear after pol change");
        @(negedge clk); pin_in[8] = 1;
        cyc(4); rd(5, 32'h0, "R5 no cause on opposite edge");
        pin_in[8] = 0;
        cyc(4); rd(5, 32'h0000_0100, "R5 falling edge cause");

        // R7 set wins over clear
        @(negedge clk); pin_in[9] = 1;
        @(negedge clk);
        wr(5, 32'h0);
        rd(5, 32'h0000_0200, "R7 set wins");

        // R8 interrupt combine
        wr(5, 32'h0);
        chk(3, 32'h0, "R8 idle irq");
        wr(7, 32'h0000_0010);
        chk(3, 32'h1, "R8 level irq");
        wr(3, 32'h0000_0110);
        chk(3, 32'h0, "R8 level low after polarity");
        wr(7, 32'h0);
        @(negedge clk); pin_in[10] = 1;
        cyc(4);
        rd(5, 32'h0000_0400, "R5 cause for irq test");
        chk(3, 32'h0, "R8 edge masked");
        wr(6, 32'h0000_0400);
        chk(3, 32'h1, "R8 edge irq");
        wr(5, 32'h0);
        chk(3, 32'h0, "R8 irq after clear");

        // R9 blink
        wr(1, 32'h0);
        wr(0, 32'h0000_0001);
        wr(2, 32'h0000_0001);
        begin
            int last_t, ntog, bad;
            logic prev;
            last_t = -1; ntog = 0; bad = 0;
            prev = pin_out[0];
            for (int t = 0; t < 6 * TC; t++) begin
                @(negedge clk);
                if (pin_out[1] !== 1'b0) bad++;
                if (pin_out[0] !== prev) begin
                    if (last_t >= 0 && (t - last_t) != TC) bad++;
                    last_t = t;
                    ntog++;
                    prev = pin_out[0];
                end
            end
            probe = (ntog >= 5) ? 32'd1 : 32'd0;
            chk(4, 32'd1, "R9 toggle count");
            probe = bad;
            chk(4, 32'd0, "R9 toggle spacing");
        end
        wr(2, 32'h0);
        chk(1, 32'h0000_0001, "R9 blink off follows out");
        wr(0, 32'h0);
        chk(1, 32'h0, "R3 out low");

        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard left %0d items", q.size());
        end
        finish_run();
    end
endmodule